// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers interrupt sources for a processor. Two local groups of eight sources each are qualified by their own mask register. An eight-source shared group of mappable sources is qualified twice, once by each of two secondary masks. Each secondary path feeds one reserved bit of one local group. Each local group reports the number of its most urgent pending source and a request line. The mappable path takes precedence whenever its cascade bit is pending.

A fixed-order arbiter then chooses among the processor-level lines. These are the two group requests, a core timer, two counter-timers and a bus-error line. Software-style mask updates arrive through per-register set and clear strobes that share one bit vector. The controller keeps the cascade bits consistent with the secondary masks by itself, so no write sequence can leave them out of step.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all four masks (local 0, local 1, secondary 0, secondary 1). With all masks clear, both requests are low and both vectors are 0 whatever the status inputs. Writes made while reset is high have no effect.
- R2: The strobe bits are indexed as follows: index 0 is local mask 0, index 1 is local mask 1, index 2 is secondary mask 0 and index 3 is secondary mask 1. A set strobe ORs `wr_bits_i` into the selected mask. A clear strobe removes those bits. The new value is visible from the next clock edge.
- R3: A group's pending vector is its status AND its local mask. The highest-numbered pending bit wins. The vector is the group base plus that bit index: base 16 for group 0 and base 24 for group 1.
- R4: A group with no pending bit outputs vector 0 with its request low. Otherwise the request is high.
- R5: When bit 2 of group 0 (its cascade bit) is pending, vector 0 comes from mappable status AND secondary mask 0, encoded with base 32. This holds even if higher local bits are pending. The vector is 0, with the request low, if that product is empty.
- R6: Bit 3 of group 1 is its cascade bit. It selects mappable status AND secondary mask 1, encoded with base 40. The same mappable status feeds both paths.
- R7: Any write that leaves a secondary mask non-zero sets the matching cascade bit in the same clock edge.
- R8: A write that leaves a secondary mask all zeros clears the matching cascade bit in the same edge. A clear that leaves other bits set keeps the cascade bit set.
- R9: Direct set or clear writes to a cascade bit position of a local mask are ignored.
- R10: `cpu_line_o` carries these bits: bit 7 is the timer, bit 6 is bus error, bit 5 is counter 1, bit 4 is counter 0, bit 3 is request 1 and bit 2 is request 0. Bits 1 and 0 are zero. The selected line follows the order 7, 2, 3, 6, 4, 5. `cpu_any_o` is low and `cpu_sel_o` is 0 when no line is raised.
- R11: When set and clear hit the same bit of the same mask in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_set_i | input | 4 | Per-mask set strobes |
| wr_clr_i | input | 4 | Per-mask clear strobes |
| wr_bits_i | input | GW | Bits to set or clear |
| l0_stat_i | input | GW | Local group 0 status |
| l1_stat_i | input | GW | Local group 1 status |
| map_stat_i | input | GW | Shared mappable status |
| timer_irq_i | input | 1 | Core timer line |
| ctr0_irq_i | input | 1 | Counter-timer 0 line |
| ctr1_irq_i | input | 1 | Counter-timer 1 line |
| buserr_irq_i | input | 1 | Bus-error line |
| vec0_o | output | VW | Group 0 source number |
| req0_o | output | 1 | Group 0 request |
| vec1_o | output | VW | Group 1 source number |
| req1_o | output | 1 | Group 1 request |
| cpu_line_o | output | 8 | Processor-level lines |
| cpu_sel_o | output | 3 | Winning line number |
| cpu_any_o | output | 1 | Any line raised |

## Verification
The bench builds the block with its defaults: eight-bit groups, cascade bits at 2 and 3, and bases 16, 24, 32 and 40. These four disjoint base ranges make every vector identify both the group and the path (local or mappable) that produced it. With the cascade bits placed on different positions in the two groups, a swapped cascade wiring or a shared secondary mask shows up directly in the vectors. Eight-bit status inputs let the bench cover the top and bottom priority positions and the empty-mappable case in a few cycles.

// File: rtl/irq_cascade_pkg.sv
`timescale 1ns/1ps
package irq_cascade_pkg;
  typedef enum logic [1:0] {
    REG_LMASK0 = 2'd0,
    REG_LMASK1 = 2'd1,
    REG_SMASK0 = 2'd2,
    REG_SMASK1 = 2'd3
  } mask_reg_e;

  localparam int NUM_GROUPS = 2;
  localparam int NUM_REGS   = 4;
  localparam int CPU_LINES  = 8;
  localparam int CPU_SEL_W  = $clog2(CPU_LINES);

  localparam int LINE_LOCAL0 = 2;
  localparam int LINE_LOCAL1 = 3;
  localparam int LINE_CTR0   = 4;
  localparam int LINE_CTR1   = 5;
  localparam int LINE_BUSERR = 6;
  localparam int LINE_TIMER  = 7;
endpackage

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  // ascending scan: the last (highest) set bit overwrites lower ones
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_mask_bank.sv
`timescale 1ns/1ps
module irq_mask_bank
  import irq_cascade_pkg::*;
#(
  parameter int GW        = 8,
  parameter int CASC0_BIT = 2,
  parameter int CASC1_BIT = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_i,
  input  logic [NUM_REGS-1:0]            set_i,
  input  logic [NUM_REGS-1:0]            clr_i,
  input  logic [GW-1:0]                  bits_i,
  output logic [NUM_GROUPS-1:0][GW-1:0]  lmask_o,
  output logic [NUM_GROUPS-1:0][GW-1:0]  smask_o
);
  localparam int CBIT [NUM_GROUPS] = '{CASC0_BIT, CASC1_BIT};

  function automatic logic [GW-1:0] apply_wr(input logic [GW-1:0] old,
                                             input logic s, input logic c,
                                             input logic [GW-1:0] b);
    logic [GW-1:0] tmp;
    tmp = c ? (old & ~b) : old;
    return s ? (tmp | b) : tmp;
  endfunction

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int LI = int'(REG_LMASK0) + g;
    localparam int SI = int'(REG_SMASK0) + g;
    logic [GW-1:0] lm_q, sm_q, lm_d, sm_d;

    always_comb begin
      sm_d = apply_wr(sm_q, set_i[SI], clr_i[SI], bits_i);
      lm_d = apply_wr(lm_q, set_i[LI], clr_i[LI], bits_i);
      // cascade bit is owned by the secondary mask
      lm_d[CBIT[g]] = |sm_d;
    end

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        lm_q <= '0;
        sm_q <= '0;
      end else begin
        lm_q <= lm_d;
        sm_q <= sm_d;
      end
    end

    assign lmask_o[g] = lm_q;
    assign smask_o[g] = sm_q;
  end
endmodule

// File: rtl/irq_group_path.sv
`timescale 1ns/1ps
module irq_group_path #(
  parameter int GW    = 8,
  parameter int VW    = 8,
  parameter int LBASE = 16,
  parameter int MBASE = 32,
  parameter int CBIT  = 2
) (
  input  logic [GW-1:0] stat_i,
  input  logic [GW-1:0] lmask_i,
  input  logic [GW-1:0] map_i,
  input  logic [GW-1:0] smask_i,
  output logic [VW-1:0] vec_o,
  output logic          req_o
);
  localparam int IW = (GW > 1) ? $clog2(GW) : 1;

  logic [GW-1:0] pend_l, pend_m;
  logic          hit_l, hit_m;
  logic [IW-1:0] idx_l, idx_m;

  assign pend_l = stat_i & lmask_i;
  assign pend_m = map_i & smask_i;

  irq_prio_enc #(.W(GW), .IW(IW)) u_enc_local (.vec_i(pend_l), .hit_o(hit_l), .idx_o(idx_l));
  irq_prio_enc #(.W(GW), .IW(IW)) u_enc_map   (.vec_i(pend_m), .hit_o(hit_m), .idx_o(idx_m));

  always_comb begin
    vec_o = '0;
    if (pend_l[CBIT]) begin
      if (hit_m) vec_o = VW'(MBASE) + VW'(idx_m);
    end else if (hit_l) begin
      vec_o = VW'(LBASE) + VW'(idx_l);
    end
  end

  assign req_o = |vec_o;
endmodule

// File: rtl/irq_cpu_arb.sv
`timescale 1ns/1ps
module irq_cpu_arb
  import irq_cascade_pkg::*;
(
  input  logic [CPU_LINES-1:0] lines_i,
  output logic [CPU_SEL_W-1:0] sel_o,
  output logic                 any_o
);
  localparam int NORD = 6;
  localparam int ORDER [NORD] = '{LINE_TIMER, LINE_LOCAL0, LINE_LOCAL1,
                                  LINE_BUSERR, LINE_CTR0, LINE_CTR1};

  // scan from lowest to highest rank so the top-ranked raised line is last written
  always_comb begin
    sel_o = '0;
    for (int i = NORD - 1; i >= 0; i--) begin
      if (lines_i[ORDER[i]]) sel_o = CPU_SEL_W'(ORDER[i]);
    end
  end

  assign any_o = |lines_i;
endmodule

// File: rtl/cascade_irq_ctrl.sv
`timescale 1ns/1ps
module cascade_irq_ctrl
  import irq_cascade_pkg::*;
#(
  parameter int GW        = 8,
  parameter int VW        = 8,
  parameter int L0_BASE   = 16,
  parameter int L1_BASE   = 24,
  parameter int M0_BASE   = 32,
  parameter int M1_BASE   = 40,
  parameter int CASC0_BIT = 2,
  parameter int CASC1_BIT = 3
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [3:0]    wr_set_i,
  input  logic [3:0]    wr_clr_i,
  input  logic [GW-1:0] wr_bits_i,
  input  logic [GW-1:0] l0_stat_i,
  input  logic [GW-1:0] l1_stat_i,
  input  logic [GW-1:0] map_stat_i,
  input  logic          timer_irq_i,
  input  logic          ctr0_irq_i,
  input  logic          ctr1_irq_i,
  input  logic          buserr_irq_i,
  output logic [VW-1:0] vec0_o,
  output logic          req0_o,
  output logic [VW-1:0] vec1_o,
  output logic          req1_o,
  output logic [7:0]    cpu_line_o,
  output logic [2:0]    cpu_sel_o,
  output logic          cpu_any_o
);
  localparam int LB [NUM_GROUPS] = '{L0_BASE, L1_BASE};
  localparam int MB [NUM_GROUPS] = '{M0_BASE, M1_BASE};
  localparam int CB [NUM_GROUPS] = '{CASC0_BIT, CASC1_BIT};

  logic [NUM_GROUPS-1:0][GW-1:0] lmask, smask, stat;
  logic [NUM_GROUPS-1:0][VW-1:0] vec;
  logic [NUM_GROUPS-1:0]         req;
  logic [GW-1:0] lmask0_q, lmask1_q, smask0_q, smask1_q;

  irq_mask_bank #(.GW(GW), .CASC0_BIT(CASC0_BIT), .CASC1_BIT(CASC1_BIT)) u_masks (
    .clk_i(clk_i), .rst_i(rst_i), .set_i(wr_set_i), .clr_i(wr_clr_i),
    .bits_i(wr_bits_i), .lmask_o(lmask), .smask_o(smask)
  );

  assign stat[0] = l0_stat_i;
  assign stat[1] = l1_stat_i;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_path
    irq_group_path #(.GW(GW), .VW(VW), .LBASE(LB[g]), .MBASE(MB[g]), .CBIT(CB[g])) u_path (
      .stat_i(stat[g]), .lmask_i(lmask[g]), .map_i(map_stat_i), .smask_i(smask[g]),
      .vec_o(vec[g]), .req_o(req[g])
    );
  end

  assign lmask0_q = lmask[0];
  assign lmask1_q = lmask[1];
  assign smask0_q = smask[0];
  assign smask1_q = smask[1];

  assign vec0_o = vec[0];
  assign req0_o = req[0];
  assign vec1_o = vec[1];
  assign req1_o = req[1];

  always_comb begin
    cpu_line_o              = '0;
    cpu_line_o[LINE_LOCAL0] = req[0];
    cpu_line_o[LINE_LOCAL1] = req[1];
    cpu_line_o[LINE_CTR0]   = ctr0_irq_i;
    cpu_line_o[LINE_CTR1]   = ctr1_irq_i;
    cpu_line_o[LINE_BUSERR] = buserr_irq_i;
    cpu_line_o[LINE_TIMER]  = timer_irq_i;
  end

  irq_cpu_arb u_arb (.lines_i(cpu_line_o), .sel_o(cpu_sel_o), .any_o(cpu_any_o));
endmodule

// File: rtl/cascade_irq_ctrl_chk.sv
`timescale 1ns/1ps
module cascade_irq_ctrl_chk #(
  parameter int GW        = 8,
  parameter int VW        = 8,
  parameter int CASC0_BIT = 2,
  parameter int CASC1_BIT = 3
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic [3:0]    wr_set_i,
  input logic [GW-1:0] wr_bits_i,
  input logic [GW-1:0] l0_stat_i,
  input logic [GW-1:0] map_stat_i,
  input logic          timer_irq_i,
  input logic [GW-1:0] lmask0,
  input logic [GW-1:0] lmask1,
  input logic [GW-1:0] smask0,
  input logic [GW-1:0] smask1,
  input logic [VW-1:0] vec0,
  input logic          req0,
  input logic [7:0]    cpu_line,
  input logic [2:0]    cpu_sel,
  input logic          cpu_any
);
  assert_reset_clears_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (lmask0 == '0 && lmask1 == '0 && smask0 == '0 && smask1 == '0));

  assert_idle_group0_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    ((l0_stat_i & lmask0) == '0) |-> (vec0 == '0 && !req0));

  assert_empty_cascade_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (l0_stat_i[CASC0_BIT] && lmask0[CASC0_BIT] && ((map_stat_i & smask0) == '0))
      |-> (vec0 == '0 && !req0));

  assert_cascade_set_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && $past(wr_set_i[2] && (wr_bits_i != '0))) |-> lmask0[CASC0_BIT]);

  assert_cascade0_clear_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (smask0 == '0) |-> !lmask0[CASC0_BIT]);

  assert_cascade1_clear_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (smask1 == '0) |-> !lmask1[CASC1_BIT]);

  assert_timer_first_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    timer_irq_i |-> (cpu_any && cpu_sel == 3'd7));

  assert_sel_raised_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    cpu_any |-> cpu_line[cpu_sel]);
endmodule

bind cascade_irq_ctrl cascade_irq_ctrl_chk #(
  .GW(GW), .VW(VW), .CASC0_BIT(CASC0_BIT), .CASC1_BIT(CASC1_BIT)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .wr_set_i(wr_set_i), .wr_bits_i(wr_bits_i),
  .l0_stat_i(l0_stat_i), .map_stat_i(map_stat_i), .timer_irq_i(timer_irq_i),
  .lmask0(lmask0_q), .lmask1(lmask1_q), .smask0(smask0_q), .smask1(smask1_q),
  .vec0(vec0_o), .req0(req0_o), .cpu_line(cpu_line_o), .cpu_sel(cpu_sel_o),
  .cpu_any(cpu_any_o)
);

// File: tb/test_cascade_irq_ctrl.sv
`timescale 1ns/1ps
module test_cascade_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] wset, wclr;
  logic [7:0] wbits, s0, s1, ms;
  logic       tmr, c0, c1, be;
  logic [7:0] vec0, vec1, line;
  logic       req0, req1, any;
  logic [2:0] sel;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state: 0 local0, 1 local1, 2 secondary0, 3 secondary1
  int mref [4];

  always #2 clk = ~clk;

  cascade_irq_ctrl i_cascade_irq_ctrl (
    .clk_i(clk), .rst_i(rst), .wr_set_i(wset), .wr_clr_i(wclr), .wr_bits_i(wbits),
    .l0_stat_i(s0), .l1_stat_i(s1), .map_stat_i(ms), .timer_irq_i(tmr),
    .ctr0_irq_i(c0), .ctr1_irq_i(c1), .buserr_irq_i(be),
    .vec0_o(vec0), .req0_o(req0), .vec1_o(vec1), .req1_o(req1),
    .cpu_line_o(line), .cpu_sel_o(sel), .cpu_any_o(any)
  );

  function automatic int top_bit(input int v, input int base);
    for (int b = 7; b >= 0; b--) if (v[b]) return base + b;
    return 0;
  endfunction

  function automatic int exp_vec(input int g);
    int st, pl, cb;
    st = (g == 0) ? int'(s0) : int'(s1);
    cb = (g == 0) ? 2 : 3;
    pl = st & mref[g];
    if (pl[cb]) return top_bit(int'(ms) & mref[2+g], (g == 0) ? 32 : 40);
    return top_bit(pl, (g == 0) ? 16 : 24);
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      for (int r = 0; r < 4; r++) mref[r] = 0;
    end else begin
      for (int r = 0; r < 4; r++) begin
        if (wclr[r]) mref[r] = mref[r] & ~int'(wbits);
        if (wset[r]) mref[r] = mref[r] | int'(wbits);
      end
      for (int g = 0; g < 2; g++) begin
        int cb = (g == 0) ? 2 : 3;
        if (mref[2+g] != 0) mref[g] = mref[g] | (1 << cb);
        else                mref[g] = mref[g] & ~(1 << cb);
      end
    end
  endtask

  task automatic step(input string tag, input logic r, input logic [3:0] st, input logic [3:0] cl,
                      input logic [7:0] b, input logic [7:0] a0, input logic [7:0] a1,
                      input logic [7:0] m, input logic [3:0] cpu);
    int e0, e1, el, es;
    rst = r; wset = st; wclr = cl; wbits = b; s0 = a0; s1 = a1; ms = m;
    {tmr, be, c1, c0} = cpu;
    #1;
    e0 = exp_vec(0);
    e1 = exp_vec(1);
    el = (int'(tmr) << 7) | (int'(be) << 6) | (int'(c1) << 5) | (int'(c0) << 4)
       | (int'(e1 != 0) << 3) | (int'(e0 != 0) << 2);
    if (tmr) es = 7; else if (e0 != 0) es = 2; else if (e1 != 0) es = 3;
    else if (be) es = 6; else if (c0) es = 4; else if (c1) es = 5; else es = 0;
    cmp(tag, "vec0", int'(vec0), e0);
    cmp(tag, "req0", int'(req0), int'(e0 != 0));
    cmp(tag, "vec1", int'(vec1), e1);
    cmp(tag, "req1", int'(req1), int'(e1 != 0));
    cmp(tag, "cpu_line", int'(line), el);
    cmp(tag, "cpu_sel", int'(sel), es);
    cmp(tag, "cpu_any", int'(any), int'(el != 0));
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  initial begin
    rst = 1; wset = 0; wclr = 0; wbits = 0; s0 = 0; s1 = 0; ms = 0;
    tmr = 0; c0 = 0; c1 = 0; be = 0;
    @(posedge clk); model_edge(); @(negedge clk);
    // R1: reset with writes and full status
    step("R1", 1, 4'hF, 4'h0, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 4'h0);
    step("R1", 0, 4'h0, 4'h0, 8'h00, 8'hFF, 8'hFF, 8'hFF, 4'h0);
    // R2/R3: set local0 upper nibble
    step("R2", 0, 4'h1, 4'h0, 8'hF0, 8'h30, 8'h00, 8'h00, 4'h0);
    step("R3", 0, 4'h0, 4'h0, 8'h00, 8'h30, 8'h00, 8'h00, 4'h0);
    step("R3", 0, 4'h0, 4'h0, 8'h00, 8'h80, 8'h00, 8'h00, 4'h0);
    step("R3", 0, 4'h0, 4'h0, 8'h00, 8'hFF, 8'h00, 8'h00, 4'h0);
    step("R4", 0, 4'h0, 4'h0, 8'h00, 8'h0F, 8'h00, 8'h00, 4'h0);
    step("R2", 0, 4'h0, 4'h1, 8'hC0, 8'hFF, 8'h00, 8'h00, 4'h0);
    step("R2", 0, 4'h0, 4'h0, 8'h00, 8'hFF, 8'h00, 8'h00, 4'h0);
    // R11: simultaneous set and clear
    step("R11", 0, 4'h1, 4'h1, 8'h01, 8'h01, 8'h00, 8'h00, 4'h0);
    step("R11", 0, 4'h0, 4'h0, 8'h00, 8'h01, 8'h00, 8'h00, 4'h0);
    // R9: direct write of cascade bit ignored
    step("R9", 0, 4'h1, 4'h0, 8'h04, 8'h04, 8'h00, 8'h00, 4'h0);
    step("R9", 0, 4'h0, 4'h0, 8'h00, 8'h04, 8'h00, 8'h00, 4'h0);
    // R7/R5: secondary 0 enables cascade, precedence over local bits
    step("R7", 0, 4'h4, 4'h0, 8'h0A, 8'hFF, 8'h00, 8'h08, 4'h0);
    step("R5", 0, 4'h0, 4'h0, 8'h00, 8'hFF, 8'h00, 8'h08, 4'h0);
    step("R5", 0, 4'h0, 4'h0, 8'h00, 8'hFF, 8'h00, 8'h00, 4'h0);
    // R6: secondary 1, shared mappable status
    step("R6", 0, 4'h8, 4'h0, 8'h80, 8'hFF, 8'h08, 8'h88, 4'h0);
    step("R6", 0, 4'h0, 4'h0, 8'h00, 8'hFF, 8'h08, 8'h88, 4'h0);
    step("R6", 0, 4'h2, 4'h0, 8'h01, 8'h04, 8'h09, 8'h02, 4'h0);
    // R9: direct clear of group 1 cascade bit ignored
    step("R9", 0, 4'h0, 4'h2, 8'h08, 8'h00, 8'h08, 8'h80, 4'h0);
    step("R9", 0, 4'h0, 4'h0, 8'h00, 8'h00, 8'h08, 8'h80, 4'h0);
    // R8: partial then full clear of secondary 0
    step("R8", 0, 4'h0, 4'h4, 8'h02, 8'hFF, 8'h00, 8'h08, 4'h0);
    step("R8", 0, 4'h0, 4'h0, 8'h00, 8'hFF, 8'h00, 8'h08, 4'h0);
    step("R8", 0, 4'h0, 4'h4, 8'h08, 8'hFF, 8'h00, 8'h08, 4'h0);
    step("R8", 0, 4'h0, 4'h0, 8'h00, 8'hFF, 8'h00, 8'h08, 4'h0);
    step("R8", 0, 4'h0, 4'h0, 8'h00, 8'h04, 8'h00, 8'hFF, 4'h0);
    // R10: arbiter order ({timer, buserr, ctr1, ctr0})
    step("R10", 0, 4'h0, 4'h0, 8'h00, 8'hFF, 8'h08, 8'h80, 4'hF);
    step("R10", 0, 4'h0, 4'h0, 8'h00, 8'h00, 8'h08, 8'h80, 4'h4);
    step("R10", 0, 4'h0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 4'h7);
    step("R10", 0, 4'h0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 4'h3);
    step("R10", 0, 4'h0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 4'h2);
    step("R10", 0, 4'h0, 4'h0, 8'h00, 8'h10, 8'h00, 8'h00, 4'h5);
    step("R10", 0, 4'h0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 4'h0);
    // R1: reset again mid-run
    step("R1", 1, 4'h0, 4'h0, 8'h00, 8'hFF, 8'hFF, 8'hFF, 4'h0);
    step("R1", 0, 4'h0, 4'h0, 8'h00, 8'hFF, 8'hFF, 8'hFF, 4'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule